// File: doc/BRIEF.md
# Automatic Erase Sequencer

This block runs the internal erase algorithm of a sectored non-volatile array. A start request arrives with two masks: the sectors the host wants cleared, and the sectors that are locked against change. A chip erase is a request with every bit set, and a sector erase is a request with the bits the command buffer collected. The block visits the requested sectors in turn and skips any that are locked. Each sector goes through two phases. First every cell is programmed to zero and checked. Then erase pulses are applied, each followed by a verify, until the array reports a clean sector.

The block talks to the array through a single request channel. A request carries an operation code and a sector index, and it stays raised until the array acknowledges it. Verify results return with the acknowledge. On the status side the block provides a busy level, a one-cycle done pulse and a sticky error flag. The error flag marks a sector that would not program to zero, or one that would not erase within the allowed number of pulses. A hardware reset abandons the work at once.

States: IDLE (waiting), SELECT (pick the lowest pending sector, or finish), PREPROG (program to zero), PVERIFY (check zeros), PULSE (one erase pulse), EVERIFY (check erasure). Transitions:

- IDLE→SELECT on start.
- SELECT→PREPROG when a sector is pending.
- SELECT→IDLE with done when none is pending.
- PREPROG→PVERIFY on acknowledge.
- PVERIFY→PULSE on pass.
- PVERIFY→IDLE with error on fail.
- PULSE→EVERIFY on acknowledge.
- EVERIFY→SELECT on pass.
- EVERIFY→PULSE on fail below the limit.
- EVERIFY→IDLE with error on fail at the limit.

Top module: `erase_seq`

## Requirements
- R1: A start request is accepted only while busy is low; a start raised while busy leaves the operation sequence unchanged.
- R2: Operations touch only sectors whose request bit is set and whose lock bit is clear, in ascending sector index order. A sector is finished before the next one starts.
- R3: For each sector the block issues program-to-zero (code 0) and then verify-zero (code 1) before any erase pulse. A failed verify-zero ends the run with error set and no further operations.
- R4: After a passed verify-zero, the block repeats erase pulse (code 2) then erase verify (code 3) until the erase verify passes.
- R5: When the erase verify after MAX_PULSES pulses fails, the block sets error and stops. At most MAX_PULSES pulses are issued per sector, and a pass on the last allowed pulse is not an error.
- R6: Busy rises in the cycle after an accepted start. It stays high until the run completes or fails.
- R7: On normal completion done is high for exactly one cycle while busy is high, and busy falls in the next cycle. Done never pulses on an error exit. Error is cleared by the next accepted start.
- R8: If no requested sector is unlocked, done is high in the cycle right after the start and no operation is issued.
- R9: Reset clears busy, done, error and the request line at once.
- R10: A raised request keeps its code and sector stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| sector_mask_i | input | NSEC | Sectors requested for erase |
| protect_mask_i | input | NSEC | Locked sectors |
| op_valid_o | output | 1 | Array operation request |
| op_kind_o | output | 2 | 0 program-zero, 1 verify-zero, 2 erase pulse, 3 erase verify |
| op_sector_o | output | $clog2(NSEC) | Target sector of the request |
| op_ack_i | input | 1 | Array finished the requested operation |
| vfy_pass_i | input | 1 | Verify result, valid with the acknowledge |
| busy_o | output | 1 | Algorithm running |
| done_o | output | 1 | One-cycle normal-completion pulse |
| error_o | output | 1 | Sticky failure flag |

## Verification
The bench feeds in masks where locked and unrequested sectors sit between requested ones. A block that scanned indices in the wrong order, or let a locked sector through, would show a sector out of order or an unexpected sector on the request channel. One sector needs exactly the maximum number of pulses and another needs one more. This separates an off-by-one limit that errors too early from one that pulses too often. Other cases are:

- a run where every requested sector is locked, which must finish at once without touching the array;
- a failed zero-verify, which must stop before any pulse;
- a start raised mid-run, which a careless block would take as a restart;
- a reset during a run, after which a block that kept state would come back busy or with error set.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_PREPROG,
        ST_PVERIFY,
        ST_PULSE,
        ST_EVERIFY
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_PROG0 = 2'd0,
        OP_VFY0  = 2'd1,
        OP_PULSE = 2'd2,
        OP_VFYE  = 2'd3
    } arr_op_e;

endpackage

// File: rtl/erase_sector_pick.sv
// Lowest-index pending sector finder.
module erase_sector_pick #(
    parameter  int NSEC = 8,
    localparam int SW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic [NSEC-1:0] pending_i,
    output logic            any_o,
    output logic [SW-1:0]   idx_o,
    output logic [NSEC-1:0] onehot_o
);

    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = NSEC - 1; i >= 0; i--) begin
            if (pending_i[i]) begin
                idx_o       = SW'(i);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |pending_i;

endmodule

// File: rtl/erase_pulse_ctr.sv
// Counts erase pulses given to the current sector.
module erase_pulse_ctr #(
    parameter  int MAX_PULSES = 4,
    localparam int CW         = $clog2(MAX_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CW'(MAX_PULSES))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit_o = (cnt_q == CW'(MAX_PULSES));

endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter  int NSEC       = 8,
    parameter  int MAX_PULSES = 4,
    localparam int SW         = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NSEC-1:0] sector_mask_i,
    input  logic [NSEC-1:0] protect_mask_i,
    output logic            op_valid_o,
    output logic [1:0]      op_kind_o,
    output logic [SW-1:0]   op_sector_o,
    input  logic            op_ack_i,
    input  logic            vfy_pass_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            error_o
);

    seq_state_e      state_q, state_d;
    logic [NSEC-1:0] work_q;
    logic [SW-1:0]   cur_q;
    logic            err_q;

    logic            pick_any;
    logic [SW-1:0]   pick_idx;
    logic [NSEC-1:0] pick_hot;
    logic            at_limit;
    logic            pv_pass;
    logic            ev_ack;

    erase_sector_pick #(.NSEC(NSEC)) u_pick (
        .pending_i (work_q),
        .any_o     (pick_any),
        .idx_o     (pick_idx),
        .onehot_o  (pick_hot)
    );

    assign pv_pass = (state_q == ST_PVERIFY) && op_ack_i && vfy_pass_i;

    erase_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (pv_pass),
        .inc_i      ((state_q == ST_PULSE) && op_ack_i),
        .at_limit_o (at_limit)
    );

    assign ev_ack = (state_q == ST_EVERIFY) && op_ack_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)  state_d = ST_SELECT;
            ST_SELECT:  state_d = pick_any ? ST_PREPROG : ST_IDLE;
            ST_PREPROG: if (op_ack_i) state_d = ST_PVERIFY;
            ST_PVERIFY: if (op_ack_i) state_d = vfy_pass_i ? ST_PULSE : ST_IDLE;
            ST_PULSE:   if (op_ack_i) state_d = ST_EVERIFY;
            ST_EVERIFY: begin
                if (op_ack_i) begin
                    if (vfy_pass_i)    state_d = ST_SELECT;
                    else if (at_limit) state_d = ST_IDLE;
                    else               state_d = ST_PULSE;
                end
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // Work list, current sector and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            cur_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && start_i) begin
                work_q <= sector_mask_i & ~protect_mask_i;
                err_q  <= 1'b0;
            end
            if ((state_q == ST_SELECT) && pick_any) begin
                cur_q  <= pick_idx;
                work_q <= work_q & ~pick_hot;
            end
            if ((state_q == ST_PVERIFY) && op_ack_i && !vfy_pass_i) begin
                err_q <= 1'b1;
            end
            if (ev_ack && !vfy_pass_i && at_limit) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        op_valid_o = 1'b0;
        op_kind_o  = OP_PROG0;
        unique case (state_q)
            ST_PREPROG: begin op_valid_o = 1'b1; op_kind_o = OP_PROG0; end
            ST_PVERIFY: begin op_valid_o = 1'b1; op_kind_o = OP_VFY0;  end
            ST_PULSE:   begin op_valid_o = 1'b1; op_kind_o = OP_PULSE; end
            ST_EVERIFY: begin op_valid_o = 1'b1; op_kind_o = OP_VFYE;  end
            default:    begin op_valid_o = 1'b0; op_kind_o = OP_PROG0; end
        endcase
        op_sector_o = cur_q;
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_SELECT) && !pick_any;
        error_o     = err_q;
    end

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk
    import erase_seq_pkg::*;
#(
    parameter  int NSEC       = 8,
    parameter  int MAX_PULSES = 4,
    localparam int SW         = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [NSEC-1:0] sector_mask_i,
    input logic [NSEC-1:0] protect_mask_i,
    input logic            op_valid_o,
    input logic [1:0]      op_kind_o,
    input logic [SW-1:0]   op_sector_o,
    input logic            op_ack_i,
    input logic            vfy_pass_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            error_o
);

    logic [NSEC-1:0] allowed_q;
    int unsigned     pulses_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            allowed_q <= '0;
            pulses_q  <= 0;
        end else begin
            if (start_i && !busy_o) allowed_q <= sector_mask_i & ~protect_mask_i;
            if (op_valid_o && op_ack_i && (op_kind_o == OP_PROG0)) pulses_q <= 0;
            else if (op_valid_o && op_ack_i && (op_kind_o == OP_PULSE)) pulses_q <= pulses_q + 1;
        end
    end

    // R2
    locked_sector_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_o |-> allowed_q[op_sector_o]);

    // R5
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= MAX_PULSES);

    // R6
    idle_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !op_valid_o);

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o && !done_o);

    // R7
    error_exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> !busy_o && !done_o);

    // R10
    request_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_o && !op_ack_i) |=> op_valid_o && $stable(op_kind_o) && $stable(op_sector_o));

endmodule

bind erase_seq erase_seq_chk #(.NSEC(NSEC), .MAX_PULSES(MAX_PULSES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sector_mask_i  (sector_mask_i),
    .protect_mask_i (protect_mask_i),
    .op_valid_o     (op_valid_o),
    .op_kind_o      (op_kind_o),
    .op_sector_o    (op_sector_o),
    .op_ack_i       (op_ack_i),
    .vfy_pass_i     (vfy_pass_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .error_o        (error_o)
);

// File: tb/erase_seq_bench.sv
`timescale 1ns/1ps
module erase_seq_bench;

    localparam int NSEC = 8;
    localparam int MAXP = 4;
    localparam int SW   = $clog2(NSEC);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start_i;
    logic [NSEC-1:0] sector_mask_i;
    logic [NSEC-1:0] protect_mask_i;
    logic            op_valid_o;
    logic [1:0]      op_kind_o;
    logic [SW-1:0]   op_sector_o;
    logic            op_ack_i;
    logic            vfy_pass_i;
    logic            busy_o;
    logic            done_o;
    logic            error_o;

    always #4 clk = ~clk;

    erase_seq #(.NSEC(NSEC), .MAX_PULSES(MAXP)) u_erase_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .sector_mask_i(sector_mask_i), .protect_mask_i(protect_mask_i),
        .op_valid_o(op_valid_o), .op_kind_o(op_kind_o), .op_sector_o(op_sector_o),
        .op_ack_i(op_ack_i), .vfy_pass_i(vfy_pass_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    typedef struct packed {
        logic [1:0]    kind;
        logic [SW-1:0] sec;
    } op_t;

    op_t exp_q[$];
    int  n_checks = 0;
    int  n_fail   = 0;
    int  need[NSEC];
    bit  pv_bad[NSEC];
    int  pulses[NSEC];
    int  ops_seen;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver side: builds the expected operation list from the requirements
    task automatic plan_run(input logic [NSEC-1:0] mask, input logic [NSEC-1:0] prot,
                            output bit exp_err, output int n_ops);
        exp_err = 0;
        n_ops   = 0;
        exp_q.delete();
        for (int s = 0; s < NSEC; s++) begin
            if (mask[s] && !prot[s]) begin
                exp_q.push_back({2'd0, SW'(s)});
                exp_q.push_back({2'd1, SW'(s)});
                n_ops += 2;
                if (pv_bad[s]) begin
                    exp_err = 1;
                    return;
                end
                for (int k = 1; k <= MAXP; k++) begin
                    exp_q.push_back({2'd2, SW'(s)});
                    exp_q.push_back({2'd3, SW'(s)});
                    n_ops += 2;
                    if (k >= need[s]) break;
                    if (k == MAXP) begin
                        exp_err = 1;
                        return;
                    end
                end
            end
        end
    endtask

    // Array model and scoreboard monitor
    initial begin
        op_t held;
        op_t cur;
        op_t e;
        bit  pend;
        bit  slow;
        op_ack_i   = 1'b0;
        vfy_pass_i = 1'b0;
        pend = 0;
        slow = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                op_ack_i = 1'b0;
                pend     = 0;
            end else if (op_ack_i) begin
                op_ack_i = 1'b0;
            end else if (op_valid_o) begin
                cur = {op_kind_o, op_sector_o};
                if (slow && !pend) begin
                    pend = 1;
                    held = cur;
                end else begin
                    if (pend) check(cur == held, "R10", "request changed before ack", int'(cur), int'(held));
                    pend = 0;
                    slow = !slow;
                    ops_seen++;
                    if (exp_q.size() == 0) begin
                        check(0, "R2", "unexpected operation", int'(cur), -1);
                    end else begin
                        e = exp_q.pop_front();
                        check(cur == e, "R2 R3 R4", "operation code/sector", int'(cur), int'(e));
                    end
                    case (op_kind_o)
                        2'd1:    vfy_pass_i = !pv_bad[op_sector_o];
                        2'd2:    begin pulses[op_sector_o]++; vfy_pass_i = 1'b0; end
                        2'd3:    vfy_pass_i = (pulses[op_sector_o] >= need[op_sector_o]);
                        default: vfy_pass_i = 1'b0;
                    endcase
                    op_ack_i = 1'b1;
                end
            end
        end
    end

    task automatic do_run(input logic [NSEC-1:0] mask, input logic [NSEC-1:0] prot,
                          input string req, input int poke_at,
                          output int first_done);
        bit exp_err;
        int n_ops;
        int cyc;
        int done_cnt;
        int fall_cyc;
        plan_run(mask, prot, exp_err, n_ops);
        for (int s = 0; s < NSEC; s++) pulses[s] = 0;
        ops_seen   = 0;
        first_done = -1;
        done_cnt   = 0;
        @(negedge clk);
        sector_mask_i  = mask;
        protect_mask_i = prot;
        start_i        = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R6", "busy after start", busy_o, 1);
        cyc      = 0;
        fall_cyc = -1;
        while (busy_o && cyc < 2000) begin
            if (done_o) begin
                done_cnt++;
                if (first_done < 0) first_done = cyc;
            end
            if (cyc == poke_at) begin
                sector_mask_i  = '1;
                protect_mask_i = '0;
                start_i        = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i  = 1'b0;
        fall_cyc = cyc;
        check(busy_o == 1'b0, "R6", {req, " busy falls at end"}, busy_o, 0);
        check(error_o == exp_err, req, "error flag at end", error_o, exp_err);
        check(done_cnt == (exp_err ? 0 : 1), "R7", {req, " done pulse count"}, done_cnt, exp_err ? 0 : 1);
        if (!exp_err)
            check(fall_cyc == first_done + 1, "R7", "busy falls right after done", fall_cyc, first_done + 1);
        check(exp_q.size() == 0, "R2", {req, " missing operations"}, exp_q.size(), 0);
        check(ops_seen == n_ops, req, "operation count", ops_seen, n_ops);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int fd;
        rst_n          = 1'b0;
        start_i        = 1'b0;
        sector_mask_i  = '0;
        protect_mask_i = '0;
        for (int s = 0; s < NSEC; s++) begin need[s] = 1; pv_bad[s] = 0; end
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && error_o == 0 && op_valid_o == 0,
              "R9", "outputs during reset", {busy_o, done_o, error_o, op_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: sparse request with a lock in the middle, varied pulse needs
        need[0] = 1; need[5] = 2; need[7] = 3;
        do_run(8'hA5, 8'h04, "R4", -1, fd);

        // R2: chip erase with the two end sectors locked
        for (int s = 0; s < NSEC; s++) need[s] = (s % 3) + 1;
        do_run(8'hFF, 8'h81, "R2", -1, fd);

        // R8: every requested sector locked
        do_run(8'h30, 8'h30, "R8", -1, fd);
        check(fd == 0, "R8", "done cycle after start", fd, 0);
        check(ops_seen == 0, "R8", "no operations", ops_seen, 0);

        // R5: pass exactly on the last allowed pulse is not an error
        need[2] = MAXP; need[6] = 1;
        do_run(8'h44, 8'h00, "R5", -1, fd);

        // R5: one pulse too many needed -> error, later sectors untouched
        need[1] = 2; need[3] = MAXP + 1; need[4] = 1;
        do_run(8'h1A, 8'h00, "R5", -1, fd);

        // R3: zero-verify failure stops before any pulse
        need[1] = 1; need[2] = 1; pv_bad[2] = 1;
        do_run(8'h0E, 8'h00, "R3", -1, fd);
        pv_bad[2] = 0;

        // R7: error cleared by the next accepted start
        do_run(8'h01, 8'h00, "R7", -1, fd);

        // R1: start raised mid-run with a different request
        need[3] = 2; need[6] = 3;
        do_run(8'h48, 8'h00, "R1", 5, fd);

        // R9: reset in the middle of a run
        plan_run(8'hFF, 8'h00, fd, fd);
        for (int s = 0; s < NSEC; s++) begin pulses[s] = 0; need[s] = MAXP; end
        @(negedge clk);
        sector_mask_i = 8'hFF; protect_mask_i = 8'h00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy_o == 0, "R9", "busy after reset", busy_o, 0);
        check(op_valid_o == 0, "R9", "request after reset", op_valid_o, 0);
        check(error_o == 0 && done_o == 0, "R9", "status after reset", {error_o, done_o}, 0);
        exp_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0, "R9", "stays idle after reset release", busy_o, 0);

        // Recovery run after reset
        for (int s = 0; s < NSEC; s++) need[s] = 1;
        do_run(8'h81, 8'h00, "R9", -1, fd);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule